// File: doc/BRIEF.md
# Serial Line Receiver with Queue, Error Flags and Idle Timeout

This block turns an asynchronous serial line into bytes. The line is oversampled by a tick enable that pulses eight times per bit period. A falling edge is treated as a candidate start bit and is confirmed only at the middle of that bit. Then seven or eight data bits are taken least significant bit first, followed by an optional parity bit and one stop bit.

Each finished character is pushed into a receive queue, and the queue reports its fill as a count. Parity mismatches, stop-bit errors, queue overflows and line breaks are kept as sticky flags until software clears them. Two event outputs tell a host when to service the queue:
- one is raised when the fill reaches a programmable threshold;
- the other is raised when data has sat unread while the line has been quiet.

When hardware handshaking is enabled, a ready-to-send output is withdrawn as the queue approaches a second programmable fill level. This lets the remote transmitter pause before bytes are lost.

Top module: `uart_rx_engine`

## Requirements
- R1: After reset the queue count is 0, all error flags and both events are low, and `rtsOut` is high.
- R2: With `cfgWide`=1, eight data bits are received least significant bit first, and bytes leave the queue in arrival order on `popData` (show-ahead, advanced by `popReq`).
- R3: With `cfgWide`=0, seven data bits are received and the stored byte has bit 7 equal to 0.
- R4: With `cfgParEn`=1, the bit after the data is checked against `cfgParMode`: 0 means the data plus parity bit hold an odd number of ones, 1 means an even number, 2 means the bit is always 0, and 3 means it is always 1. A mismatch sets `errParity`.
- R5: A stop bit sampled low sets `errFraming`, the character is still queued, and no new start is accepted until the line has been seen high.
- R6: A start is confirmed by sampling the line at tick 4 after the falling edge is seen. A pulse that is high again at that point produces no character.
- R7: A character completed while the queue holds DEPTH bytes, with no pop in the same cycle, is dropped and sets `errOverflow`. The count stays at DEPTH and the stored contents are unchanged.
- R8: `evDataAvail` is high while the count is at least `cfgTrigLevel`; a threshold of 0 acts as 1.
- R9: `rtsOut` is low while `cfgFlowEn`=1 and the count is at least `cfgFlowLevel`; otherwise it is high.
- R10: `evTimeout` is high when the count is nonzero and at least 32 × (frame bits) ticks have passed since the last confirmed start or pop. Frame bits means start + data + parity + stop. A pop drops it on the next cycle.
- R11: A `fifoFlush` pulse empties the queue on the next cycle.
- R12: `breakSeen` is set once the line has stayed low for (frame bits + `cfgBreakLen`) × 8 ticks; a single all-zero character with a low stop bit is not long enough.
- R13: `errClear` clears all four sticky flags. A `popReq` while the queue is empty has no effect on the count or on later data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling enable, eight per bit period |
| rxLine | input | 1 | Serial input line, idle high |
| cfgWide | input | 1 | 1 = eight data bits, 0 = seven |
| cfgParEn | input | 1 | Parity bit present |
| cfgParMode | input | 2 | Parity rule (see R4) |
| cfgFlowEn | input | 1 | Enable automatic ready-to-send drop |
| cfgTrigLevel | input | 5 | Data-available threshold |
| cfgFlowLevel | input | 5 | Fill at which `rtsOut` drops |
| cfgBreakLen | input | 4 | Extra bit times of low line required for break |
| popReq | input | 1 | Remove the head byte |
| fifoFlush | input | 1 | Discard all queued bytes |
| errClear | input | 1 | Clear sticky error flags |
| popData | output | 8 | Head byte of the queue |
| fifoLevel | output | 7 | Number of queued bytes |
| evDataAvail | output | 1 | Fill at or above threshold |
| evTimeout | output | 1 | Unread data with a quiet line |
| errParity | output | 1 | Sticky parity error |
| errFraming | output | 1 | Sticky stop-bit error |
| errOverflow | output | 1 | Sticky overflow |
| breakSeen | output | 1 | Sticky break detect |
| rtsOut | output | 1 | Ready-to-send, high = may transmit |

## Verification
A misplaced bit counter or a wrong sampling phase shows on `popData` as shifted or mixed-up bits one character later. A rejected start that is wrongly accepted shows within one frame as a spurious count increment. Queue pointer or count faults appear at `fifoLevel` the cycle after a push or pop, and they also appear as wrong order or contents when the queue is drained, which is why overflow is checked by reading back the oldest byte. The idle and low-line counters are only visible through `evTimeout` and `breakSeen`, so the bench samples them on both sides of their thresholds, a few dozen ticks apart.

// File: rtl/rx_serial_pkg.sv
package rx_serial_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_HOLD
  } rxState_e;

  // Strobes from bit-timing control into the byte datapath.
  typedef struct packed {
    logic       startFrame;
    logic       sampleData;
    logic [2:0] bitIdx;
    logic       sampleParity;
    logic       sampleStop;
    logic       bitVal;
  } rxStrobe_t;

  localparam logic [1:0] PAR_ODD   = 2'd0;
  localparam logic [1:0] PAR_EVEN  = 2'd1;
  localparam logic [1:0] PAR_SPACE = 2'd2;
  localparam logic [1:0] PAR_MARK  = 2'd3;

endpackage

// File: rtl/rx_bit_ctrl.sv
module rx_bit_ctrl
  import rx_serial_pkg::*;
#(
  parameter int OVERSAMPLE = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      rxLine,
  input  logic      cfgWide,
  input  logic      cfgParEn,
  output rxStrobe_t strobe
);

  localparam int PH_W = $clog2(OVERSAMPLE);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVERSAMPLE / 2 - 1);

  rxState_e        state;
  logic [PH_W-1:0] phaseCnt;
  logic [2:0]      bitCnt;
  logic [2:0]      lastBit;
  logic            midTick;
  logic            startCheck;

  assign lastBit    = cfgWide ? 3'd7 : 3'd6;
  assign midTick    = tick && (phaseCnt == PH_LAST);
  assign startCheck = (state == ST_START) && tick && (phaseCnt == PH_MID);

  always_comb begin
    strobe = '0;
    strobe.bitIdx = bitCnt;
    strobe.bitVal = rxLine;
    case (state)
      ST_START:  strobe.startFrame   = startCheck && !rxLine;
      ST_DATA:   strobe.sampleData   = midTick;
      ST_PARITY: strobe.sampleParity = midTick;
      ST_STOP:   strobe.sampleStop   = midTick;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          phaseCnt <= '0;
          if (!rxLine) state <= ST_START;
        end
        ST_START: begin
          if (phaseCnt == PH_MID) begin
            phaseCnt <= '0;
            bitCnt   <= '0;
            state    <= rxLine ? ST_IDLE : ST_DATA;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_DATA: begin
          phaseCnt <= (phaseCnt == PH_LAST) ? '0 : phaseCnt + 1'b1;
          if (phaseCnt == PH_LAST) begin
            if (bitCnt == lastBit) state <= cfgParEn ? ST_PARITY : ST_STOP;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_PARITY: begin
          phaseCnt <= (phaseCnt == PH_LAST) ? '0 : phaseCnt + 1'b1;
          if (phaseCnt == PH_LAST) state <= ST_STOP;
        end
        ST_STOP: begin
          phaseCnt <= (phaseCnt == PH_LAST) ? '0 : phaseCnt + 1'b1;
          if (phaseCnt == PH_LAST) state <= rxLine ? ST_IDLE : ST_HOLD;
        end
        ST_HOLD: begin
          phaseCnt <= '0;
          if (rxLine) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: a start high at its midpoint returns to idle
  p_start_reject_r6: assert property (@(posedge clk) disable iff (!rstN)
    (startCheck && rxLine) |=> (state == ST_IDLE));

  // R2: at most one sampling strobe per cycle
  p_strobe_exclusive_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.startFrame, strobe.sampleData, strobe.sampleParity, strobe.sampleStop}));

  // R5: after a low stop bit, no start is taken before the line is high
  p_hold_after_bad_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !rxLine) |=> (state == ST_HOLD));

endmodule

// File: rtl/rx_store_path.sv
module rx_store_path
  import rx_serial_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int LEVEL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               rxLine,
  input  rxStrobe_t          strobe,
  input  logic               cfgWide,
  input  logic               cfgParEn,
  input  logic [1:0]         cfgParMode,
  input  logic               cfgFlowEn,
  input  logic [4:0]         cfgTrigLevel,
  input  logic [4:0]         cfgFlowLevel,
  input  logic [3:0]         cfgBreakLen,
  input  logic               popReq,
  input  logic               fifoFlush,
  input  logic               errClear,
  output logic [7:0]         popData,
  output logic [LEVEL_W-1:0] fifoLevel,
  output logic               evDataAvail,
  output logic               evTimeout,
  output logic               errParity,
  output logic               errFraming,
  output logic               errOverflow,
  output logic               breakSeen,
  output logic               rtsOut
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [7:0]       dataReg;
  logic             expParity;
  logic             full, popOk, doPush;
  logic [4:0]       frameBits;
  logic [7:0]       breakThresh;
  logic [9:0]       timeThresh;
  logic [9:0]       idleCnt;
  logic [7:0]       lowCnt;
  logic [4:0]       trigEff;

  assign frameBits   = 5'd9 + {4'd0, cfgWide} + {4'd0, cfgParEn};
  assign breakThresh = {frameBits + {1'b0, cfgBreakLen}, 3'b000};
  assign timeThresh  = {frameBits, 5'b00000};
  assign full        = (int'(fifoLevel) == DEPTH);
  assign popOk       = popReq && (fifoLevel != '0);
  assign doPush      = strobe.sampleStop && (!full || popOk);
  assign popData     = mem[rdPtr];
  assign trigEff     = (cfgTrigLevel == 5'd0) ? 5'd1 : cfgTrigLevel;
  assign evDataAvail = int'(fifoLevel) >= int'(trigEff);
  assign rtsOut      = !(cfgFlowEn && (int'(fifoLevel) >= int'(cfgFlowLevel)));
  assign evTimeout   = (fifoLevel != '0) && (idleCnt >= timeThresh);

  always_comb begin
    case (cfgParMode)
      PAR_ODD:   expParity = ~^dataReg;
      PAR_EVEN:  expParity = ^dataReg;
      PAR_SPACE: expParity = 1'b0;
      default:   expParity = 1'b1;
    endcase
  end

  // character assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataReg <= '0;
    else if (strobe.startFrame) dataReg <= '0;
    else if (strobe.sampleData) dataReg[strobe.bitIdx] <= strobe.bitVal;
  end

  always_ff @(posedge clk) begin
    if (doPush && !fifoFlush) mem[wrPtr] <= dataReg;
  end

  // queue pointers and count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoLevel <= '0;
    end else if (fifoFlush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoLevel <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (popOk)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, popOk})
        2'b10:   fifoLevel <= fifoLevel + 1'b1;
        2'b01:   fifoLevel <= fifoLevel - 1'b1;
        default: ;
      endcase
    end
  end

  // sticky flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errParity   <= 1'b0;
      errFraming  <= 1'b0;
      errOverflow <= 1'b0;
      breakSeen   <= 1'b0;
    end else begin
      if (errClear) begin
        errParity   <= 1'b0;
        errFraming  <= 1'b0;
        errOverflow <= 1'b0;
        breakSeen   <= 1'b0;
      end
      if (strobe.sampleParity && (strobe.bitVal != expParity)) errParity <= 1'b1;
      if (strobe.sampleStop && !strobe.bitVal) errFraming <= 1'b1;
      if (strobe.sampleStop && full && !popOk && !fifoFlush) errOverflow <= 1'b1;
      if (lowCnt >= breakThresh) breakSeen <= 1'b1;
    end
  end

  // quiet-line timer and low-line timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
      lowCnt  <= '0;
    end else begin
      if (fifoFlush || popOk || strobe.startFrame) idleCnt <= '0;
      else if (tick && (idleCnt < timeThresh)) idleCnt <= idleCnt + 1'b1;
      if (tick) begin
        if (rxLine) lowCnt <= '0;
        else if (lowCnt != 8'hFF) lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    int'(fifoLevel) <= DEPTH);

  p_overflow_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sampleStop && full && !popReq && !fifoFlush) |=> (errOverflow && int'(fifoLevel) == DEPTH));

  p_pop_clears_timeout_r10: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && fifoLevel != '0) |=> !evTimeout);

  p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rstN)
    fifoFlush |=> (fifoLevel == '0));

  p_first_push_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sampleStop && fifoLevel == '0 && !fifoFlush) |=> (fifoLevel == LEVEL_W'(1)));

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import rx_serial_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxLine,
  input  logic       cfgWide,
  input  logic       cfgParEn,
  input  logic [1:0] cfgParMode,
  input  logic       cfgFlowEn,
  input  logic [4:0] cfgTrigLevel,
  input  logic [4:0] cfgFlowLevel,
  input  logic [3:0] cfgBreakLen,
  input  logic       popReq,
  input  logic       fifoFlush,
  input  logic       errClear,
  output logic [7:0] popData,
  output logic [6:0] fifoLevel,
  output logic       evDataAvail,
  output logic       evTimeout,
  output logic       errParity,
  output logic       errFraming,
  output logic       errOverflow,
  output logic       breakSeen,
  output logic       rtsOut
);

  rxStrobe_t strobe;

  rx_bit_ctrl #(.OVERSAMPLE(8)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .rxLine   (rxLine),
    .cfgWide  (cfgWide),
    .cfgParEn (cfgParEn),
    .strobe   (strobe)
  );

  rx_store_path #(.DEPTH(DEPTH), .LEVEL_W(7)) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .tick         (tick),
    .rxLine       (rxLine),
    .strobe       (strobe),
    .cfgWide      (cfgWide),
    .cfgParEn     (cfgParEn),
    .cfgParMode   (cfgParMode),
    .cfgFlowEn    (cfgFlowEn),
    .cfgTrigLevel (cfgTrigLevel),
    .cfgFlowLevel (cfgFlowLevel),
    .cfgBreakLen  (cfgBreakLen),
    .popReq       (popReq),
    .fifoFlush    (fifoFlush),
    .errClear     (errClear),
    .popData      (popData),
    .fifoLevel    (fifoLevel),
    .evDataAvail  (evDataAvail),
    .evTimeout    (evTimeout),
    .errParity    (errParity),
    .errFraming   (errFraming),
    .errOverflow  (errOverflow),
    .breakSeen    (breakSeen),
    .rtsOut       (rtsOut)
  );

endmodule

// File: tb/test_uart_rx_engine.sv
module test_uart_rx_engine;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b1;
  logic       rxLine = 1'b1;
  logic       cfgWide = 1'b1;
  logic       cfgParEn = 1'b0;
  logic [1:0] cfgParMode = 2'd0;
  logic       cfgFlowEn = 1'b0;
  logic [4:0] cfgTrigLevel = 5'd16;
  logic [4:0] cfgFlowLevel = 5'd20;
  logic [3:0] cfgBreakLen = 4'd2;
  logic       popReq = 1'b0;
  logic       fifoFlush = 1'b0;
  logic       errClear = 1'b0;
  logic [7:0] popData;
  logic [6:0] fifoLevel;
  logic       evDataAvail, evTimeout, errParity, errFraming, errOverflow, breakSeen, rtsOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_engine #(.DEPTH(DEPTH)) i_uart_rx_engine (
    .clk(clk), .rstN(rstN), .tick(tick), .rxLine(rxLine),
    .cfgWide(cfgWide), .cfgParEn(cfgParEn), .cfgParMode(cfgParMode),
    .cfgFlowEn(cfgFlowEn), .cfgTrigLevel(cfgTrigLevel), .cfgFlowLevel(cfgFlowLevel),
    .cfgBreakLen(cfgBreakLen), .popReq(popReq), .fifoFlush(fifoFlush), .errClear(errClear),
    .popData(popData), .fifoLevel(fifoLevel), .evDataAvail(evDataAvail), .evTimeout(evTimeout),
    .errParity(errParity), .errFraming(errFraming), .errOverflow(errOverflow),
    .breakSeen(breakSeen), .rtsOut(rtsOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic v);
    rxLine = v;
    waitClk(8);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int nb, input bit usePar,
                           input bit parBit, input bit stopBit);
    sendBit(1'b0);
    for (int i = 0; i < nb; i++) sendBit(d[i]);
    if (usePar) sendBit(parBit);
    sendBit(stopBit);
    rxLine = 1'b1;
    waitClk(2);
  endtask

  task automatic popOne(output logic [7:0] d);
    d = popData;
    popReq = 1'b1;
    waitClk(1);
    popReq = 1'b0;
  endtask

  task automatic flushAll();
    fifoFlush = 1'b1;
    errClear = 1'b1;
    waitClk(1);
    fifoFlush = 1'b0;
    errClear = 1'b0;
  endtask

  function automatic bit parityFor(input logic [7:0] d, input logic [1:0] mode);
    case (mode)
      2'd0:    return ~^d;
      2'd1:    return ^d;
      2'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic tReset();
    chk("R1 level", fifoLevel, 0);
    chk("R1 flags", {errParity, errFraming, errOverflow, breakSeen}, 0);
    chk("R1 events", {evDataAvail, evTimeout}, 0);
    chk("R1 rts", rtsOut, 1);
  endtask

  task automatic tEightBit();
    logic [7:0] d;
    sendFrame(8'hA5, 8, 0, 0, 1);
    sendFrame(8'h3C, 8, 0, 0, 1);
    chk("R2 level", fifoLevel, 2);
    popOne(d); chk("R2 first byte", d, 8'hA5);
    popOne(d); chk("R2 second byte", d, 8'h3C);
    chk("R2 flags clean", {errParity, errFraming}, 0);
  endtask

  task automatic tSevenBit();
    logic [7:0] d;
    cfgWide = 1'b0;
    sendFrame(8'hD5, 7, 0, 0, 1);
    popOne(d); chk("R3 seven-bit byte", d, 8'h55);
    cfgWide = 1'b1;
    flushAll();
  endtask

  task automatic tParity();
    logic [7:0] d;
    cfgParEn = 1'b1;
    for (int m = 0; m < 4; m++) begin
      cfgParMode = 2'(m);
      sendFrame(8'hB3, 8, 1, parityFor(8'hB3, 2'(m)), 1);
      chk($sformatf("R4 good parity mode %0d", m), errParity, 0);
      popOne(d); chk($sformatf("R4 data mode %0d", m), d, 8'hB3);
      sendFrame(8'hB3, 8, 1, ~parityFor(8'hB3, 2'(m)), 1);
      chk($sformatf("R4 bad parity mode %0d", m), errParity, 1);
      flushAll();
    end
    cfgParEn = 1'b0;
    cfgParMode = 2'd0;
  endtask

  task automatic tFraming();
    logic [7:0] d;
    sendFrame(8'h81, 8, 0, 0, 0);
    chk("R5 framing flag", errFraming, 1);
    chk("R5 byte kept", fifoLevel, 1);
    popOne(d); chk("R5 byte value", d, 8'h81);
    flushAll();
  endtask

  task automatic tGlitch();
    rxLine = 1'b0;
    waitClk(3);
    rxLine = 1'b1;
    waitClk(100);
    chk("R6 glitch rejected", fifoLevel, 0);
    chk("R6 no error", errFraming, 0);
  endtask

  task automatic tOverflow();
    logic [7:0] d;
    for (int i = 0; i <= DEPTH; i++) sendFrame(8'(i), 8, 0, 0, 1);
    chk("R7 level held", fifoLevel, DEPTH);
    chk("R7 overflow flag", errOverflow, 1);
    popOne(d); chk("R7 oldest intact", d, 0);
    flushAll();
  endtask

  task automatic tTrigger();
    cfgTrigLevel = 5'd3;
    sendFrame(8'h11, 8, 0, 0, 1);
    sendFrame(8'h22, 8, 0, 0, 1);
    chk("R8 below trigger", evDataAvail, 0);
    sendFrame(8'h33, 8, 0, 0, 1);
    chk("R8 at trigger", evDataAvail, 1);
    flushAll();
    cfgTrigLevel = 5'd0;
    waitClk(1);
    chk("R8 zero trigger empty", evDataAvail, 0);
    sendFrame(8'h44, 8, 0, 0, 1);
    chk("R8 zero trigger acts as one", evDataAvail, 1);
    flushAll();
    cfgTrigLevel = 5'd16;
  endtask

  task automatic tFlow();
    logic [7:0] d;
    cfgFlowEn = 1'b1;
    cfgFlowLevel = 5'd4;
    for (int i = 0; i < 3; i++) sendFrame(8'(i + 5), 8, 0, 0, 1);
    chk("R9 rts below level", rtsOut, 1);
    sendFrame(8'h09, 8, 0, 0, 1);
    chk("R9 rts dropped", rtsOut, 0);
    popOne(d);
    chk("R9 rts restored", rtsOut, 1);
    sendFrame(8'h0A, 8, 0, 0, 1);
    cfgFlowEn = 1'b0;
    waitClk(1);
    chk("R9 rts when disabled", rtsOut, 1);
    flushAll();
    cfgFlowLevel = 5'd20;
  endtask

  task automatic tTimeout();
    logic [7:0] d;
    sendFrame(8'h61, 8, 0, 0, 1);
    sendFrame(8'h62, 8, 0, 0, 1);
    waitClk(200);
    chk("R10 before window", evTimeout, 0);
    waitClk(60);
    chk("R10 after window", evTimeout, 1);
    popOne(d);
    chk("R10 pop clears", evTimeout, 0);
    chk("R10 data remains", fifoLevel, 1);
  endtask

  task automatic tFlush();
    fifoFlush = 1'b1;
    waitClk(1);
    fifoFlush = 1'b0;
    chk("R11 flushed level", fifoLevel, 0);
    chk("R11 no timeout", evTimeout, 0);
  endtask

  task automatic tBreak();
    sendFrame(8'h00, 8, 0, 0, 0);
    chk("R12 single zero frame no break", breakSeen, 0);
    rxLine = 1'b0;
    waitClk(120);
    rxLine = 1'b1;
    waitClk(4);
    chk("R12 long low is break", breakSeen, 1);
  endtask

  task automatic tClearAndEmptyPop();
    logic [7:0] d;
    errClear = 1'b1;
    waitClk(1);
    errClear = 1'b0;
    chk("R13 flags cleared", {errParity, errFraming, errOverflow, breakSeen}, 0);
    fifoFlush = 1'b1; waitClk(1); fifoFlush = 1'b0;
    popReq = 1'b1; waitClk(1); popReq = 1'b0;
    chk("R13 empty pop ignored", fifoLevel, 0);
    sendFrame(8'h5A, 8, 0, 0, 1);
    chk("R13 level after empty pop", fifoLevel, 1);
    popOne(d); chk("R13 data after empty pop", d, 8'h5A);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(2);
    tReset();
    tEightBit();
    tSevenBit();
    tParity();
    tFraming();
    tGlitch();
    tOverflow();
    tTrigger();
    tFlow();
    tTimeout();
    tFlush();
    tBreak();
    tClearAndEmptyPop();
    finishRun();
  end

endmodule